// File: doc/BRIEF.md
# Port Event Counter Bank

The block keeps one saturating 8-bit event counter for each of 13 repeater ports. Each cycle, a one-cycle pulse on a port's event line adds one to that port's counter. An active-low bulk-decrement strobe, asynchronous to the core clock, takes one off every counter at once. The host reads a counter through a simple registered read port. A counter that reaches full scale raises an interrupt source, and an active-low interrupt output reports any source that is not masked.

The decrement path has three steps. The strobe passes through a two-flop synchronizer, and then an edge detector finds the falling edge. A small state machine then releases the decrement. The machine has two states. `DEC_IDLE` is the resting state. On a detected falling edge with no event pulse on any port, it applies the decrement in the same cycle and stays in `DEC_IDLE`. On a falling edge that coincides with an event pulse, it takes the *defer* transition to `DEC_HOLD`. `DEC_HOLD` waits for the first cycle with no event pulse. In that cycle it applies the decrement and takes the *release* transition back to `DEC_IDLE`. Because of this, an increment and a decrement never land on a counter in the same cycle, and neither is lost.

Reading a counter's address clears that counter's interrupt source. A mask register holds one bit per source.

Top module: `port_event_counter_bank`

## Requirements
- R1: A synchronous reset clears all counters, all interrupt sources, all mask bits and any held decrement, and drives irq_n high.
- R2: Each cycle in which bit i of event_pulse is high increments counter i by one. Other counters are unchanged.
- R3: A counter at 255 stays at 255 on further increments.
- R4: rd_en high with rd_addr = i (0..12) puts counter i on rd_data one cycle later. Addresses 13..15 return 0.
- R5: Each falling edge of dec_n decrements every counter by exactly one. This happens after the two-flop synchronizer. Holding dec_n low gives no further decrements.
- R6: A counter at 0 stays at 0 on a decrement.
- R7: A decrement that coincides with an event pulse on any port is held. It is applied in the first cycle with no event pulse. Both the increment and the decrement take effect.
- R8: Any increment that leaves counter i at 255 sets interrupt source i. irq_n is low whenever any unmasked source is set.
- R9: A read of address i clears source i. A read of another address leaves source i set.
- R10: When mask_wdata bit i (written with mask_we) is 1, source i no longer drives irq_n, but the source stays recorded. Clearing the mask bit makes irq_n go low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| event_pulse | input | 13 | Per-port increment request, one count per high cycle |
| dec_n | input | 1 | Asynchronous bulk-decrement strobe, active low |
| rd_en | input | 1 | Counter read request |
| rd_addr | input | 4 | Counter index to read |
| rd_data | output | 8 | Registered counter value |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 13 | Mask value, 1 blocks the source |
| irq_n | output | 1 | Interrupt, active low |

## Verification
The bench first drives increments on two ports at different rates. It then applies a bulk decrement with dec_n held low for many cycles, which separates the detection of an edge from a level-sensitive decrement. It also lets a zero counter meet that decrement, which shows the floor at zero. A decrement that falls entirely inside a run of event pulses tests deferral against a lost or merged operation. A 260-cycle run on one port separates saturation from wrap-around and drives the interrupt. Reads of a different address and of the source address, together with mask toggling, show that each source is cleared and masked on its own.

// File: rtl/pecb_pkg.sv
package pecb_pkg;
    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_HOLD = 1'b1
    } dec_state_e;
endpackage

// File: rtl/pecb_dec_ctrl.sv
module pecb_dec_ctrl
    import pecb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dec_n_async,
    input  logic any_event,
    output logic dec_apply
);
    // Shift chain: [0] first sync flop, [1] second sync flop, [2] previous sample
    logic [2:0] sync_q;
    logic       fall_seen;
    dec_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 3'b111;
        else     sync_q <= {sync_q[1:0], dec_n_async};
    end

    assign fall_seen = sync_q[2] & ~sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) state_q <= DEC_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        dec_apply = 1'b0;
        unique case (state_q)
            DEC_IDLE: begin
                if (fall_seen) begin
                    if (any_event) state_d   = DEC_HOLD;   // defer
                    else           dec_apply = 1'b1;
                end
            end
            DEC_HOLD: begin
                if (!any_event) begin
                    dec_apply = 1'b1;
                    state_d   = DEC_IDLE;                  // release
                end
            end
            default: state_d = DEC_IDLE;
        endcase
    end

    // R7: a decrement never lands in a cycle with an increment
    assert_no_collision_R7: assert property (@(posedge clk) disable iff (rst)
        dec_apply |-> !any_event);
    // R7: a held decrement resolves in the first quiet cycle
    assert_hold_release_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == DEC_HOLD && !any_event) |=> (state_q == DEC_IDLE));
endmodule

// File: rtl/pecb_counter.sv
module pecb_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_max
);
    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc) begin
            if (cnt != MAX_V) cnt <= cnt + 1'b1;
        end else if (dec) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign hit_max = inc && (cnt >= MAX_V - 1'b1);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt == MAX_V) |=> (cnt == MAX_V));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && cnt == '0) |=> (cnt == '0));
    assert_inc_step_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && cnt != MAX_V) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/pecb_irq.sv
module pecb_irq #(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic [NUM_SRC-1:0] clr_vec,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            mask_q <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_vec) | set_vec;
            if (mask_we) mask_q <= mask_wdata;
        end
    end

    assign irq_n = ~|(flag_q & ~mask_q);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        assert_clear_on_access_R9: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
        assert_set_sticky_R8: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr_vec[i]) |=> flag_q[i]);
    end

    assert_mask_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (&mask_q) |-> irq_n);
endmodule

// File: rtl/port_event_counter_bank.sv
module port_event_counter_bank #(
    parameter int NUM_PORTS = 13,
    parameter int CNT_W     = 8,
    parameter int ADDR_W    = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] event_pulse,
    input  logic                 dec_n,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [CNT_W-1:0]     rd_data,
    input  logic                 mask_we,
    input  logic [NUM_PORTS-1:0] mask_wdata,
    output logic                 irq_n
);
    logic                 any_event;
    logic                 dec_apply;
    logic [CNT_W-1:0]     cnt_arr [NUM_PORTS];
    logic [NUM_PORTS-1:0] hit_vec;
    logic [NUM_PORTS-1:0] clr_vec;
    logic [CNT_W-1:0]     rd_sel;

    assign any_event = |event_pulse;

    pecb_dec_ctrl u_dec (
        .clk        (clk),
        .rst        (rst),
        .dec_n_async(dec_n),
        .any_event  (any_event),
        .dec_apply  (dec_apply)
    );

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        pecb_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .inc    (event_pulse[i]),
            .dec    (dec_apply),
            .cnt    (cnt_arr[i]),
            .hit_max(hit_vec[i])
        );
        assign clr_vec[i] = rd_en && (rd_addr == ADDR_W'(i));
    end

    pecb_irq #(.NUM_SRC(NUM_PORTS)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (hit_vec),
        .clr_vec   (clr_vec),
        .mask_we   (mask_we),
        .mask_wdata(mask_wdata),
        .irq_n     (irq_n)
    );

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rd_addr == ADDR_W'(i)) rd_sel = cnt_arr[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_sel;
    end

    assert_bad_addr_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(|clr_vec)) |=> (rd_data == '0));
    assert_reset_irq_R1: assert property (@(posedge clk)
        rst |=> irq_n);
endmodule

// File: tb/port_event_counter_bank_bench.sv
module port_event_counter_bank_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] event_pulse;
    logic        dec_n;
    logic        rd_en;
    logic [3:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        mask_we;
    logic [12:0] mask_wdata;
    logic        irq_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    port_event_counter_bank u_port_event_counter_bank (
        .clk(clk), .rst(rst), .event_pulse(event_pulse), .dec_n(dec_n),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int addr, output int val);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = 4'(addr);
        @(negedge clk);
        val   = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic pulse(input int port, input int cycles);
        @(negedge clk);
        event_pulse[port] = 1'b1;
        repeat (cycles) @(negedge clk);
        event_pulse[port] = 1'b0;
    endtask

    task automatic set_mask(input logic [12:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        chk("R1 irq_n after reset", irq_n, 1);
        for (int i = 0; i < 13; i++) begin
            rd(i, v);
            chk($sformatf("R1 counter %0d after reset", i), v, 0);
        end
    endtask

    task automatic t_increment;
        int v;
        pulse(3, 5);
        pulse(7, 2);
        rd(3, v); chk("R2 port3 after 5 events", v, 5);
        rd(7, v); chk("R2 port7 after 2 events", v, 2);
        rd(0, v); chk("R2 port0 untouched", v, 0);
    endtask

    task automatic t_decrement;
        int v;
        @(negedge clk); dec_n = 1'b0;
        repeat (6) @(negedge clk);
        rd(3, v); chk("R5 port3 after one edge", v, 4);
        rd(7, v); chk("R5 port7 after one edge", v, 1);
        rd(0, v); chk("R6 port0 floor at zero", v, 0);
        repeat (10) @(negedge clk);
        rd(3, v); chk("R5 strobe held low no more decrements", v, 4);
        dec_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_collision;
        int v;
        @(negedge clk);
        event_pulse[3] = 1'b1;
        dec_n = 1'b0;
        repeat (8) @(negedge clk);
        event_pulse[3] = 1'b0;
        repeat (6) @(negedge clk);
        dec_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(3, v); chk("R7 port3 keeps 8 incs and 1 dec", v, 11);
        rd(7, v); chk("R7 held decrement reaches port7", v, 0);
    endtask

    task automatic t_saturate;
        int v;
        chk("R8 irq_n idle before saturation", irq_n, 1);
        pulse(5, 255);
        chk("R8 irq_n low at full scale", irq_n, 0);
        pulse(5, 5);
        rd(5, v); chk("R3 port5 saturated", v, 255);
        chk("R9 irq_n cleared by own read", irq_n, 1);
        pulse(5, 1);
        chk("R8 irq_n after inc at max", irq_n, 0);
        rd(7, v);
        chk("R9 other read leaves irq", irq_n, 0);
        rd(5, v);
        chk("R9 own read clears irq", irq_n, 1);
    endtask

    task automatic t_mask;
        int v;
        set_mask(13'h0020);
        pulse(5, 1);
        chk("R10 masked source keeps irq_n high", irq_n, 1);
        set_mask(13'h0000);
        chk("R10 unmask exposes recorded source", irq_n, 0);
        rd(5, v);
        chk("R10 cleared after read", irq_n, 1);
    endtask

    task automatic t_bad_addr;
        int v;
        rd(13, v); chk("R4 address 13 reads zero", v, 0);
        rd(15, v); chk("R4 address 15 reads zero", v, 0);
        rd(3, v);  chk("R4 valid address reads count", v, 11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; event_pulse = '0; dec_n = 1'b1; rd_en = 1'b0;
        rd_addr = '0; mask_we = 1'b0; mask_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_increment();
        t_decrement();
        t_collision();
        t_bad_addr();
        t_saturate();
        t_mask();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule